// File: doc/BRIEF.md
# Blocking Fully-Associative Write-Back Line Cache

This block is a small data cache placed between several requesters and a single memory port. Any line can live in any slot; slots are found by comparing the stored line address. The cache serves one request at a time. After a request is taken, the tag comparison happens a fixed, parameterised number of cycles later. A hit reads the line, or merges write bytes into it, and answers the requester that sent it.

A miss goes to memory. A request that covers the whole line (all byte enables set) is passed to memory as it is. Any partial access, read or write, first fetches the whole line. When every slot is valid, a pseudo-random resident line is written back and its slot is freed before the new line is installed. The held access is then replayed against the installed line. Hit and miss counts and the latency of the most recent miss are exported.

Requests carry a line address, a read/write flag, a byte-enable mask over the line and write data as wide as the line. An access can therefore never cross a line boundary. Responses always return the full line contents as they stand after the access. Requesters always accept responses.

Top module: `assoc_wb_cache`

## Requirements
- R1: One request at most is in service. In every cycle after an acceptance until the response cycle, all `req_ready` bits are low. When several requesters are valid while the cache is idle, the lowest index is accepted and every higher index sees `req_ready` low.
- R2: The response goes only to the requester that was accepted. `rsp_valid` is one-hot for exactly one cycle, with `rsp_data` equal to the line after the access.
- R3: A hit answers with `rsp_valid` high exactly ACCESS_LAT+1 cycles after the cycle in which the request was accepted.
- R4: On a miss with all byte enables set, memory gets one request at the same line address. A read is a read. A write is a write carrying the request data. Every memory request, read or write, is answered by exactly one `mem_rsp_valid` pulse. A memory request stays unchanged while `mem_req_ready` is low.
- R5: On a miss with a partial byte-enable mask, memory gets one read of that line. The request is then completed on the fetched line as a hit, and a write is allocated into the cache.
- R6: A write changes only the bytes whose enable bit is set; byte b of the line is bits 8b+7..8b.
- R7: The cache holds NUM_LINES lines. While any slot is invalid, no miss produces a write-back.
- R8: On a miss with all slots valid, one resident line is written to memory as a full-line write with its own address and current data. That write follows the fetch and precedes the response, and the evicted line is no longer resident afterwards.
- R9: In the cycle `rsp_valid` is high, the cache is already idle: `req_ready` is high for every requester whose lower-index neighbours are not valid, so a new request can be taken in that same cycle.
- R10: `hit_count` and `miss_count` increase by one per hit and per miss, counted at tag comparison.
- R11: `miss_latency` holds the cycles from miss detection to line install for the latest miss. With memory always ready and answering D cycles after acceptance, this is D+2 without a write-back and 2D+3 with one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_REQ | Request present, one bit per requester |
| req_ready | output | NUM_REQ | Request taken this cycle when valid |
| req_write | input | NUM_REQ | 1 = write, 0 = read, per requester |
| req_addr | input | NUM_REQ*LADDR_W | Line address, requester i in slice i |
| req_be | input | NUM_REQ*LINE_BYTES | Byte enables over the line |
| req_wdata | input | NUM_REQ*LINE_BYTES*8 | Write data over the line |
| rsp_valid | output | NUM_REQ | One-hot response strobe |
| rsp_data | output | LINE_BYTES*8 | Line contents after the access |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = full-line write, 0 = line read |
| mem_req_addr | output | LADDR_W | Memory line address |
| mem_req_data | output | LINE_BYTES*8 | Write data for memory |
| mem_rsp_valid | input | 1 | Memory answer strobe |
| mem_rsp_data | input | LINE_BYTES*8 | Line read from memory |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |
| miss_latency | output | CNT_W | Cycles of the latest miss |

## Verification
The hardest state to reach from the ports is a miss on a full cache. Here the victim is random and the bench cannot know in advance which line will leave. The stimulus first fills every slot with distinct lines. It then keeps missing on fresh addresses, some with contention from a second requester. The reference model does not predict the victim. It accepts any write-back whose address is resident in its own copy, checks that the data matches, and drops that line. Later reads of evicted addresses confirm that the written-back data reached memory.

// File: rtl/awc_pkg.sv
package awc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FETCH,
    ST_FETCH_WAIT,
    ST_EVICT,
    ST_EVICT_WAIT,
    ST_INSTALL
  } awc_state_e;
endpackage

// File: rtl/awc_prio_open.sv
module awc_prio_open #(
  parameter int N = 2
) (
  input  logic [N-1:0] valid,
  output logic [N-1:0] open_mask
);
  logic seen;
  always_comb begin
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      open_mask[i] = !seen;
      seen         = seen | valid[i];
    end
  end
endmodule

// File: rtl/awc_lfsr.sv
module awc_lfsr #(
  parameter int         W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  always_comb q_d = q[0] ? ((q >> 1) ^ TAPS) : (q >> 1);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= q_d;
  end

  // victim source never locks up in the all-zero state
  a_r8_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
endmodule

// File: rtl/awc_store.sv
module awc_store #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 8,
  parameter int LINE_W    = 32,
  parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [LINE_W-1:0] lk_data,
  output logic              all_valid,
  output logic [IDX_W-1:0]  free_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx
);
  logic [NUM_LINES-1:0] valid_q, valid_d, match;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [LINE_W-1:0]    data_q [NUM_LINES];

  always_comb begin
    valid_d = valid_q;
    if (wr_en)  valid_d[wr_idx]  = 1'b1;
    if (inv_en) valid_d[inv_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    lk_idx   = '0;
    free_idx = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (match[i]) lk_idx = IDX_W'(i);
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (!valid_q[i]) free_idx = IDX_W'(i);
  end

  assign lk_hit    = |match;
  assign lk_data   = data_q[lk_idx];
  assign all_valid = &valid_q;
  assign rd_tag    = tag_q[rd_idx];
  assign rd_data   = data_q[rd_idx];

  // a line address is resident in one slot at most
  a_r5_unique_line: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
  // only a resident line is ever released by eviction
  a_r8_evict_resident: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |-> valid_q[inv_idx]);
endmodule

// File: rtl/assoc_wb_cache.sv
module assoc_wb_cache
  import awc_pkg::*;
#(
  parameter int NUM_REQ    = 2,
  parameter int LADDR_W    = 8,
  parameter int LINE_BYTES = 4,
  parameter int NUM_LINES  = 4,
  parameter int ACCESS_LAT = 2,
  parameter int CNT_W      = 16,
  parameter int LFSR_W     = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REQ-1:0]               req_valid,
  output logic [NUM_REQ-1:0]               req_ready,
  input  logic [NUM_REQ-1:0]               req_write,
  input  logic [NUM_REQ*LADDR_W-1:0]       req_addr,
  input  logic [NUM_REQ*LINE_BYTES-1:0]    req_be,
  input  logic [NUM_REQ*LINE_BYTES*8-1:0]  req_wdata,
  output logic [NUM_REQ-1:0]               rsp_valid,
  output logic [LINE_BYTES*8-1:0]          rsp_data,
  output logic                             mem_req_valid,
  input  logic                             mem_req_ready,
  output logic                             mem_req_write,
  output logic [LADDR_W-1:0]               mem_req_addr,
  output logic [LINE_BYTES*8-1:0]          mem_req_data,
  input  logic                             mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]          mem_rsp_data,
  output logic [CNT_W-1:0]                 hit_count,
  output logic [CNT_W-1:0]                 miss_count,
  output logic [CNT_W-1:0]                 miss_latency
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int IDX_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int RID_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam int LAT_W  = $clog2(ACCESS_LAT + 1);

  function automatic logic [LINE_W-1:0] merge_bytes(input logic [LINE_W-1:0] base,
                                                    input logic [LINE_W-1:0] wd,
                                                    input logic [LINE_BYTES-1:0] be);
    logic [LINE_W-1:0] r;
    r = base;
    for (int b = 0; b < LINE_BYTES; b++)
      if (be[b]) r[b*8 +: 8] = wd[b*8 +: 8];
    return r;
  endfunction

  awc_state_e          state_q, state_d;
  logic                idle, accept, lookup_now, rsp_fire, full_line;
  logic [NUM_REQ-1:0]  open_mask, take, rsp_valid_d;
  logic [RID_W-1:0]    sel_id, h_id;
  logic [LADDR_W-1:0]  sel_addr, h_tag;
  logic                sel_write, h_write;
  logic [LINE_BYTES-1:0] sel_be, h_be;
  logic [LINE_W-1:0]   sel_wdata, h_wdata, fill_q, upd_line, fill_line, rsp_line;
  logic [LAT_W-1:0]    wait_q, wait_d;
  logic [IDX_W-1:0]    vic_q, vic_pick;
  logic [LFSR_W-1:0]   lfsr_q;
  logic [CNT_W-1:0]    hit_q, miss_q, mlat_q, mlat_run_q, mlat_run_d;
  logic                lk_hit, all_valid, st_wr_en, st_inv_en;
  logic [IDX_W-1:0]    lk_idx, free_idx, st_wr_idx;
  logic [LINE_W-1:0]   lk_data, vic_data, st_wr_data;
  logic [LADDR_W-1:0]  vic_tag;

  awc_prio_open #(.N(NUM_REQ)) u_prio (.valid(req_valid), .open_mask(open_mask));

  awc_lfsr #(.W(LFSR_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .q(lfsr_q));

  awc_store #(.NUM_LINES(NUM_LINES), .TAG_W(LADDR_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_tag(h_tag), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_data(lk_data),
    .all_valid(all_valid), .free_idx(free_idx),
    .rd_idx(vic_q), .rd_tag(vic_tag), .rd_data(vic_data),
    .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_tag(h_tag), .wr_data(st_wr_data),
    .inv_en(st_inv_en), .inv_idx(vic_q)
  );

  // request side
  assign idle      = (state_q == ST_IDLE);
  assign req_ready = idle ? open_mask : '0;
  assign take      = req_valid & req_ready;
  assign accept    = |take;

  always_comb begin
    sel_id = '0;
    for (int i = 0; i < NUM_REQ; i++)
      if (take[i]) sel_id = RID_W'(i);
    sel_addr  = req_addr[sel_id*LADDR_W +: LADDR_W];
    sel_write = req_write[sel_id];
    sel_be    = req_be[sel_id*LINE_BYTES +: LINE_BYTES];
    sel_wdata = req_wdata[sel_id*LINE_W +: LINE_W];
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      h_id    <= sel_id;
      h_tag   <= sel_addr;
      h_write <= sel_write;
      h_be    <= sel_be;
      h_wdata <= sel_wdata;
    end
  end

  // datapath
  assign full_line  = &h_be;
  assign lookup_now = (state_q == ST_WAIT) && (wait_q == '0);
  assign upd_line   = h_write ? merge_bytes(lk_data, h_wdata, h_be) : lk_data;
  assign fill_line  = h_write ? merge_bytes(fill_q, h_wdata, h_be) : fill_q;
  assign rsp_fire   = (lookup_now && lk_hit) || (state_q == ST_INSTALL);
  assign rsp_line   = (state_q == ST_INSTALL) ? fill_line : upd_line;
  assign vic_pick   = IDX_W'(lfsr_q % NUM_LINES);

  assign st_wr_en   = (lookup_now && lk_hit && h_write) || (state_q == ST_INSTALL);
  assign st_wr_idx  = (state_q == ST_INSTALL) ? free_idx : lk_idx;
  assign st_wr_data = rsp_line;
  assign st_inv_en  = (state_q == ST_EVICT_WAIT) && mem_rsp_valid;

  // memory side
  assign mem_req_valid = (state_q == ST_FETCH) || (state_q == ST_EVICT);
  assign mem_req_write = (state_q == ST_EVICT) || (h_write && full_line);
  assign mem_req_addr  = (state_q == ST_EVICT) ? vic_tag : h_tag;
  assign mem_req_data  = (state_q == ST_EVICT) ? vic_data : h_wdata;

  // next state
  always_comb begin
    state_d    = state_q;
    wait_d     = wait_q;
    mlat_run_d = mlat_run_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_WAIT;
        wait_d  = LAT_W'(ACCESS_LAT - 1);
      end
      ST_WAIT: begin
        if (wait_q != '0)     wait_d = wait_q - 1'b1;
        else if (lk_hit)      state_d = ST_IDLE;
        else begin
          state_d    = ST_FETCH;
          mlat_run_d = '0;
        end
      end
      ST_FETCH: begin
        mlat_run_d = mlat_run_q + 1'b1;
        if (mem_req_ready) state_d = ST_FETCH_WAIT;
      end
      ST_FETCH_WAIT: begin
        mlat_run_d = mlat_run_q + 1'b1;
        if (mem_rsp_valid) state_d = all_valid ? ST_EVICT : ST_INSTALL;
      end
      ST_EVICT: begin
        mlat_run_d = mlat_run_q + 1'b1;
        if (mem_req_ready) state_d = ST_EVICT_WAIT;
      end
      ST_EVICT_WAIT: begin
        mlat_run_d = mlat_run_q + 1'b1;
        if (mem_rsp_valid) state_d = ST_INSTALL;
      end
      ST_INSTALL: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    rsp_valid_d = rsp_fire ? (NUM_REQ'(1) << h_id) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      wait_q     <= '0;
      mlat_run_q <= '0;
      mlat_q     <= '0;
      hit_q      <= '0;
      miss_q     <= '0;
      rsp_valid  <= '0;
    end else begin
      state_q    <= state_d;
      wait_q     <= wait_d;
      mlat_run_q <= mlat_run_d;
      rsp_valid  <= rsp_valid_d;
      if (lookup_now && lk_hit)     hit_q  <= hit_q + 1'b1;
      if (lookup_now && !lk_hit)    miss_q <= miss_q + 1'b1;
      if (state_q == ST_INSTALL)    mlat_q <= mlat_run_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_fire) rsp_data <= rsp_line;
    if ((state_q == ST_FETCH_WAIT) && mem_rsp_valid) begin
      fill_q <= mem_rsp_data;
      if (all_valid) vic_q <= vic_pick;
    end
  end

  assign hit_count    = hit_q;
  assign miss_count   = miss_q;
  assign miss_latency = mlat_q;

  // R1: an acceptance closes the door for the following cycle
  a_r1_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    |(req_valid & req_ready) |=> (req_ready == '0));
  // R1: never two requesters taken together
  a_r1_single_take: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_valid & req_ready));
  // R2: a response addresses one requester only
  a_r2_onehot_rsp: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rsp_valid));
  // R9: the cache is open again while its answer is on the bus
  a_r9_open_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> req_ready[0]);
  // R4: a stalled memory request holds still
  a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
  // R5: the replayed line is not already resident when installed
  a_r5_install_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INSTALL) |-> !lk_hit);
  // R7: a write-back is only issued when no slot is free
  a_r7_no_early_evict: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && !(h_write && full_line)) |-> all_valid);
endmodule

// File: tb/assoc_wb_cache_bench.sv
module assoc_wb_cache_bench;
  localparam int NR  = 2;
  localparam int AW  = 8;
  localparam int LB  = 4;
  localparam int NL  = 4;
  localparam int LAT = 2;
  localparam int D   = 3;
  localparam int LW  = LB * 8;

  logic            clk, rst_n;
  logic [NR-1:0]   req_valid, req_ready, req_write, rsp_valid;
  logic [NR*AW-1:0] req_addr;
  logic [NR*LB-1:0] req_be;
  logic [NR*LW-1:0] req_wdata;
  logic [LW-1:0]   rsp_data, mem_req_data, mem_rsp_data;
  logic            mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [AW-1:0]   mem_req_addr;
  logic [15:0]     hit_count, miss_count, miss_latency;

  assoc_wb_cache #(.NUM_REQ(NR), .LADDR_W(AW), .LINE_BYTES(LB), .NUM_LINES(NL),
                   .ACCESS_LAT(LAT)) u_assoc_wb_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .hit_count(hit_count), .miss_count(miss_count), .miss_latency(miss_latency));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int hits_e = 0, misses_e = 0;
  logic [LW-1:0] cache_m [int];
  logic [LW-1:0] mem_m   [int];
  int            cur_addr, cd;
  logic [LW-1:0] cur_wdata, rsp_buf;
  bit            wb_seen;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] pat(int a);
    logic [7:0] b = 8'(a);
    return {b ^ 8'hA5, b, ~b, 8'h3C};
  endfunction

  function automatic logic [LW-1:0] mem_rd(int a);
    return mem_m.exists(a) ? mem_m[a] : pat(a);
  endfunction

  function automatic logic [LW-1:0] mrg(logic [LW-1:0] base, logic [LW-1:0] wd, logic [LB-1:0] be);
    logic [LW-1:0] r = base;
    for (int b = 0; b < LB; b++) if (be[b]) r[b*8 +: 8] = wd[b*8 +: 8];
    return r;
  endfunction

  // memory model: always ready, answers every request D cycles after acceptance
  always @(negedge clk) begin
    if (rst_n) begin
      mem_rsp_valid = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rsp_buf;
        end
      end
      if (mem_req_valid) begin
        if (mem_req_write) begin
          if (cache_m.exists(int'(mem_req_addr))) begin
            chk("R8 write-back data", 64'(mem_req_data), 64'(cache_m[int'(mem_req_addr)]));
            cache_m.delete(int'(mem_req_addr));
            wb_seen = 1'b1;
          end else begin
            chk("R4 forwarded write addr", 64'(mem_req_addr), 64'(cur_addr));
            chk("R4 forwarded write data", 64'(mem_req_data), 64'(cur_wdata));
          end
          mem_m[int'(mem_req_addr)] = mem_req_data;
          rsp_buf = '0;
        end else begin
          chk("R5 fetch addr", 64'(mem_req_addr), 64'(cur_addr));
          rsp_buf = mem_rd(int'(mem_req_addr));
        end
        cd = D;
      end
    end
  end

  task automatic do_access(int id, int addr, bit wr, logic [LB-1:0] be,
                           logic [LW-1:0] wd, bit contend);
    bit hit, evict;
    int target, other;
    logic [LW-1:0] base, exp_line;
    hit      = cache_m.exists(addr);
    evict    = !hit && (cache_m.num() == NL);
    base     = hit ? cache_m[addr] : mem_rd(addr);
    exp_line = wr ? mrg(base, wd, be) : base;
    target   = hit ? LAT : (evict ? LAT + 3 + 2*D : LAT + 2 + D);
    other    = 1 - id;
    cur_addr = addr; cur_wdata = wd; wb_seen = 1'b0;

    req_valid = '0;
    req_valid[id] = 1'b1;
    req_write[id] = wr;
    req_addr[id*AW +: AW]  = AW'(addr);
    req_be[id*LB +: LB]    = be;
    req_wdata[id*LW +: LW] = wd;
    if (contend) begin
      req_valid[other] = 1'b1;
      req_write[other] = 1'b0;
      req_addr[other*AW +: AW] = AW'(addr + 1);
      req_be[other*LB +: LB]   = '1;
    end
    #1;
    chk("R9 ready before accept", 64'(req_ready[id]), 64'd1);
    if (contend && other > id) chk("R1 priority refuses higher index", 64'(req_ready[other]), 64'd0);
    @(posedge clk); @(negedge clk);
    req_valid[id] = 1'b0;
    chk("R2 no response at accept", 64'(rsp_valid), 64'd0);
    chk("R1 busy after accept", 64'(req_ready), 64'd0);
    for (int k = 1; k <= target; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == target) begin
        chk(hit ? "R3 hit response timing" : "R2 miss response strobe",
            64'(rsp_valid), 64'(NR'(1) << id));
        chk(wr ? "R6 line after write" : "R2 response data", 64'(rsp_data), 64'(exp_line));
        chk("R9 open in response cycle", 64'(req_ready), 64'({NR{1'b1}}));
      end else begin
        chk("R3 response timing", 64'(rsp_valid), 64'd0);
        chk("R1 busy while serving", 64'(req_ready), 64'd0);
      end
    end
    if (hit) hits_e++; else misses_e++;
    chk("R10 hit count", 64'(hit_count), 64'(hits_e));
    chk("R10 miss count", 64'(miss_count), 64'(misses_e));
    if (!hit) begin
      chk("R11 miss latency", 64'(miss_latency), evict ? 64'(2*D + 3) : 64'(D + 2));
      chk(evict ? "R8 write-back on full cache" : "R7 no write-back with free slot",
          64'(wb_seen), 64'(evict));
    end
    cache_m[addr] = exp_line;
    if (contend) req_valid[other] = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int keys[$];
    rst_n = 1'b0; cd = 0;
    req_valid = '0; req_write = '0; req_addr = '0; req_be = '0; req_wdata = '0;
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 reset ready", 64'(req_ready), 64'({NR{1'b1}}));
    chk("R2 reset no response", 64'(rsp_valid), 64'd0);
    chk("R4 reset no memory request", 64'(mem_req_valid), 64'd0);
    chk("R10 reset hit count", 64'(hit_count), 64'd0);
    chk("R10 reset miss count", 64'(miss_count), 64'd0);
    @(negedge clk);

    do_access(0, 'h10, 1'b0, 4'b0011, '0, 1'b0);             // R5 partial read miss
    do_access(1, 'h10, 1'b0, 4'hF, '0, 1'b0);                // R3 hit
    do_access(0, 'h10, 1'b1, 4'b0100, 32'hDEADBEEF, 1'b0);   // R6 partial write hit
    do_access(1, 'h10, 1'b0, 4'b0001, '0, 1'b0);             // R6 readback
    do_access(0, 'h20, 1'b1, 4'hF, 32'h12345678, 1'b0);      // R4 full-line write miss
    do_access(1, 'h30, 1'b1, 4'b1001, 32'hCAFEF00D, 1'b0);   // R5 write-allocate
    do_access(0, 'h40, 1'b0, 4'hF, '0, 1'b0);                // R4 full read miss, R7 last free slot
    do_access(0, 'h50, 1'b0, 4'b0010, '0, 1'b1);             // R8 eviction under contention, R1
    do_access(1, 'h51, 1'b0, 4'hF, '0, 1'b0);                // R1 refused requester served next
    for (int i = 0; i < 8; i++)
      do_access(i % 2, 'h60 + i*3, i[0], 4'(4'b0001 << (i % 4)), 32'hA0B0C0D0 + i, 1'b0);
    keys.delete();
    foreach (cache_m[a]) keys.push_back(a);
    foreach (keys[j]) do_access(j % 2, keys[j], 1'b0, 4'hF, '0, 1'b0);   // R3 hits on residents
    do_access(0, 'h20, 1'b0, 4'hF, '0, 1'b0);                // R8 data came back from memory
    do_access(1, 'h30, 1'b0, 4'b0110, '0, 1'b0);
    do_access(0, 'h10, 1'b1, 4'hF, 32'h0BADF00D, 1'b1);      // R4 full write, contended
    do_access(1, 'h11, 1'b0, 4'hF, '0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule